// File: doc/BRIEF.md
# Offset-Preset Modulo-6 Sequencer

This block is a 4-bit synchronous up-counter that steps through six states, 9 to 14, and then starts again at 9. It never passes through zero. It is built from a general binary counter stage with a parallel load, a count enable and a carry output. The modulus comes from a synchronous reload of the nonzero start value whenever the terminal value 14 is reached. The counter is never cleared asynchronously on a decoded value. That kind of clear exists only for a moment and may leave some flip-flops unchanged.

A synchronous reset also presets the count to 9 instead of clearing it. An external load lets the user place any 4-bit value into the counter, including values outside the six-state loop. From such a value the counter increments in plain binary, wrapping from 15 to 0, until it reaches 14 and enters the loop. A registered wrap pulse marks each return from 14 to 9. A carry output reports the all-ones state while counting is enabled, so that stages can be chained.

Top module: `offset_mod6_seq`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `count` becomes 9 and `wrap` becomes 0 after that edge.
- R2: With `rst`=0, `ld`=0, `cnt_en`=1 and `count` not equal to 14, the next edge sets `count` to (`count`+1) mod 16, so 15 is followed by 0.
- R3: With `rst`=0, `ld`=0, `cnt_en`=1 and `count`=14, the next edge sets `count` to 9. Free running from reset, the sequence is 9,10,11,12,13,14,9,... with period 6.
- R4: With `rst`=0 and `ld`=1, the next edge sets `count` to `ld_data` whatever the value of `cnt_en`, and this also overrides the reload at 14.
- R5: With `rst`=0, `ld`=0 and `cnt_en`=0, `count` keeps its value at the next edge, and this includes a held value of 14.
- R6: `carry_out` is a combinational output equal to 1 exactly when `cnt_en`=1 and `count`=15, independent of `ld`.
- R7: `wrap` is 1 for exactly the one cycle after an edge at which the reload of R3 replaced 14 by 9. It is 0 after a reset, after an external load (even a load of 9) and after a hold.
- R8: `rst` takes priority over `ld` and `cnt_en`: a reset edge with `ld`=1 still gives `count`=9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, presets the count to 9 |
| cnt_en | input | 1 | Count enable |
| ld | input | 1 | Parallel load request |
| ld_data | input | 4 | Value taken by a parallel load |
| count | output | 4 | Registered counter value |
| carry_out | output | 1 | High while counting is enabled at value 15 |
| wrap | output | 1 | One-cycle pulse after the counter returns from 14 to 9 |

## Verification
The bench loads every one of the 16 start values and applies each combination of load and enable from it. This covers a 14 that is held, which must not reload or pulse `wrap`, and a load while at 14, which must win over the reload. A design that decoded 14 without the enable would leave the held state, and one that ranked the reload above the load would ignore `ld_data`. Values 15 and 0 lie outside the loop: a design that decoded the terminal value on fewer bits would jump early, and a carry that ignored the enable would fire while the counter is held. A reset asserted together with a load must still produce 9, and `wrap` must stay low after a load of 9.

// File: rtl/offset_mod6_pkg.sv
package offset_mod6_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_RESET = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_WRAP  = 2'd3
  } load_src_e;
endpackage

// File: rtl/offset_mod6_detect.sv
module offset_mod6_detect #(
  parameter int WIDTH    = 4,
  parameter int TERMINAL = 14
) (
  input  logic [WIDTH-1:0] q_i,
  output logic             term_hit_o
);
  localparam logic [WIDTH-1:0] TERM_V = TERMINAL[WIDTH-1:0];

  logic [WIDTH-1:0] bit_match;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_match
      assign bit_match[i] = ~(q_i[i] ^ TERM_V[i]);
    end
  endgenerate

  assign term_hit_o = &bit_match;
endmodule

// File: rtl/offset_mod6_ctrl.sv
module offset_mod6_ctrl
  import offset_mod6_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int PRESET = 9
) (
  input  logic             rst_i,
  input  logic             ext_ld_i,
  input  logic [WIDTH-1:0] ext_data_i,
  input  logic             cnt_en_i,
  input  logic             term_hit_i,
  output logic             core_ld_o,
  output logic [WIDTH-1:0] core_data_o,
  output logic             wrap_next_o
);
  localparam logic [WIDTH-1:0] PRESET_V = PRESET[WIDTH-1:0];

  load_src_e src;

  always_comb begin
    if (rst_i)                        src = SRC_RESET;
    else if (ext_ld_i)                src = SRC_EXT;
    else if (cnt_en_i && term_hit_i)  src = SRC_WRAP;
    else                              src = SRC_NONE;
  end

  always_comb begin
    core_ld_o   = (src != SRC_NONE);
    core_data_o = (src == SRC_EXT) ? ext_data_i : PRESET_V;
    wrap_next_o = (src == SRC_WRAP);
  end
endmodule

// File: rtl/offset_mod6_core.sv
module offset_mod6_core #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] tog;

  assign tog[0] = en_i;
  genvar i;
  generate
    for (i = 1; i < WIDTH; i++) begin : g_chain
      assign tog[i] = tog[i-1] & q[i-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ld_i) q <= d_i;
    else      q <= q ^ tog;
  end

  assign q_o     = q;
  assign carry_o = tog[WIDTH-1] & q[WIDTH-1];

  // R6: carry on enabled increment means the next value is zero
  a_r6_carry_rolls: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && carry_o) |=> (q == '0));
endmodule

// File: rtl/offset_mod6_seq.sv
module offset_mod6_seq
  import offset_mod6_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int PRESET   = 9,
  parameter int TERMINAL = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_data,
  output logic [WIDTH-1:0] count,
  output logic             carry_out,
  output logic             wrap
);
  localparam logic [WIDTH-1:0] PRESET_V = PRESET[WIDTH-1:0];
  localparam logic [WIDTH-1:0] TERM_V   = TERMINAL[WIDTH-1:0];

  logic             term_hit;
  logic             core_ld;
  logic [WIDTH-1:0] core_data;
  logic             wrap_next;
  logic             wrap_q;

  offset_mod6_detect #(.WIDTH(WIDTH), .TERMINAL(TERMINAL)) u_detect (
    .q_i        (count),
    .term_hit_o (term_hit)
  );

  offset_mod6_ctrl #(.WIDTH(WIDTH), .PRESET(PRESET)) u_ctrl (
    .rst_i       (rst),
    .ext_ld_i    (ld),
    .ext_data_i  (ld_data),
    .cnt_en_i    (cnt_en),
    .term_hit_i  (term_hit),
    .core_ld_o   (core_ld),
    .core_data_o (core_data),
    .wrap_next_o (wrap_next)
  );

  offset_mod6_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .en_i    (cnt_en),
    .ld_i    (core_ld),
    .d_i     (core_data),
    .q_o     (count),
    .carry_o (carry_out)
  );

  always_ff @(posedge clk) begin
    if (rst) wrap_q <= 1'b0;
    else     wrap_q <= wrap_next;
  end
  assign wrap = wrap_q;

  // R1 / R8: reset presets, even with load asserted
  a_r1_reset_preset: assert property (@(posedge clk)
    rst |=> (count == PRESET_V && !wrap));
  // R2: increment off the terminal value
  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (!ld && cnt_en && count != TERM_V) |=> (count == $past(count) + 1'b1));
  // R3: terminal value reloads the preset
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (!ld && cnt_en && count == TERM_V) |=> (count == PRESET_V));
  // R4: external load wins over count and reload
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> (count == $past(ld_data) && !wrap));
  // R5: hold keeps the value and raises no pulse
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld && !cnt_en) |=> ($stable(count) && !wrap));
  // R7: the pulse only ever accompanies the preset value
  a_r7_wrap_value: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (count == PRESET_V));
endmodule

// File: tb/sim_offset_mod6_seq.sv
module sim_offset_mod6_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       ld = 1'b0;
  logic [3:0] ld_data = 4'd0;
  logic [3:0] count;
  logic       carry_out;
  logic       wrap;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_c    = 9;
  int exp_w    = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  offset_mod6_seq u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld(ld), .ld_data(ld_data),
    .count(count), .carry_out(carry_out), .wrap(wrap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at the falling edge, check carry, clock, then check count and wrap
  task automatic step(input bit r, input bit l, input bit e, input int d,
                      input string req_c, input string req_w);
    @(negedge clk);
    rst = r; ld = l; cnt_en = e; ld_data = d[3:0];
    #1;
    if (!r) chk(carry_out == (e && exp_c == 15), "R6 carry", int'(carry_out),
                int'(e && exp_c == 15));
    if (r)                    begin exp_c = 9; exp_w = 0; end
    else if (l)               begin exp_c = d; exp_w = 0; end
    else if (e && exp_c == 14) begin exp_c = 9; exp_w = 1; end
    else if (e)               begin exp_c = (exp_c + 1) % 16; exp_w = 0; end
    else                      exp_w = 0;
    @(posedge clk);
    #1;
    chk(int'(count) == exp_c, req_c, int'(count), exp_c);
    chk(int'(wrap) == exp_w, req_w, int'(wrap), exp_w);
  endtask

  initial begin
    // R1 reset state
    step(1, 0, 0, 0, "R1 count", "R1 wrap");
    // R8 reset beats load and enable
    step(1, 1, 1, 3, "R8 count", "R8 wrap");
    // R3 free run: two full periods
    for (int k = 0; k < 12; k++) step(0, 0, 1, 0, "R3 sequence", "R7 wrap pulse");
    // near-exhaustive sweep of start value and control mode
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 4; m++) begin
        step(0, 1, 0, s, "R4 load start", "R7 wrap after load");
        case (m)
          0: step(0, 0, 0, 7, "R5 hold", "R5 no wrap on hold");
          1: step(0, 0, 1, 7, (s == 14) ? "R3 reload" : "R2 increment",
                  "R7 wrap pulse");
          2: step(0, 1, 0, (s * 5 + 3) % 16, "R4 load no enable", "R7 wrap after load");
          default: step(0, 1, 1, (s + 9) % 16, "R4 load over count", "R7 wrap after load");
        endcase
        step(0, 0, 1, 0, "R2 follow-on count", "R7 pulse one cycle");
      end
    end
    // load of 9 raises no pulse; long hold at 14
    step(0, 1, 1, 9, "R4 load 9", "R7 no wrap on load 9");
    step(0, 1, 0, 14, "R4 load 14", "R7 wrap after load");
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, "R5 hold at 14", "R5 no wrap");
    step(0, 0, 1, 0, "R3 reload after hold", "R7 wrap pulse");
    step(0, 0, 1, 0, "R2 after wrap", "R7 pulse ends");
    // from 15: carry, roll to 0, climb back into loop
    step(0, 1, 0, 15, "R4 load 15", "R7 wrap after load");
    for (int k = 0; k < 17; k++) step(0, 0, 1, 0, "R2 roll-through", "R7 wrap pulse");
    step(0, 0, 0, 0, "R5 hold", "R5 no wrap");
    step(1, 0, 1, 0, "R1 reset again", "R1 wrap cleared");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule